// File: doc/BRIEF.md
# SMBus host command sequencer

This block is the transaction engine of an SMBus host controller. Software reaches it through six byte-wide registers: status, control, command, target address, data low and data high. A write to control with the start bit set launches one transaction of the selected type: quick, send/receive byte, byte-data or word-data. When the transaction ends, the busy flag drops and exactly one sticky result flag is raised. Software clears each result flag by writing a one to it.

Toward the bus the block issues byte-level operations on a simple request/done link. The operations are: generate a start or repeated start, transmit a byte and return its acknowledge, receive a byte and answer with ACK or NACK, and generate a stop. A separate bit-level engine carries out these operations on the wires. A read that needs a command byte first sends the target address with the write bit. It then sends the command byte, issues a repeated start and resends the address with the read bit.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset every register reads 0x00 and no link request is raised.
- R2: Writing control with bit 6 set while idle sets status bit 0 (busy) from the next cycle. Control bit 6 always reads back 0. When the transaction ends, busy clears in the same cycle that exactly one of status bits 1 (done), 2 (device error) or 4 (failed) is set. Success leaves status = 0x02.
- R3: Control bits [4:2] pick the transaction type: 0 quick, 1 byte, 2 byte-data, 3 word-data. The link operation codes are 0 start, 1 transmit, 2 receive, 3 stop. The number of link operations is 3 for quick, 4 for byte, 5 for a byte-data write, 7 for a byte-data read, 6 for a word-data write and 8 for a word-data read. The last address byte on the link is address register bits [7:1] followed by its bit 0 (1 = read).
- R4: A byte write transmits the command register. A byte-data write transmits the command register and then data low (register 4). A word-data write transmits the command register, then data low, then data high (register 5).
- R5: A byte or byte-data read stores the received byte in data low and leaves data high unchanged. A word-data read stores the first byte in data low and the second in data high. The last received byte is answered with NACK and any earlier one with ACK.
- R6: A transmitted byte that is not acknowledged ends the transaction with a stop, clears busy and sets status bit 2.
- R7: Writing control with bit 1 set while busy ends the transaction with a stop once the current link operation finishes, and sets status bit 4. The same write while idle has no effect on the next transaction.
- R8: Type codes 4 to 7 set status bit 4 and clear busy without issuing any link operation.
- R9: Writing 1 to status bits 1 to 4 clears them and writing 0 leaves them set, so result flags accumulate until cleared. Status bit 0 cannot be written.
- R10: While busy, a start request is ignored. Writes to control (other than the kill bit), command, address and both data registers are also ignored.
- R11: Register addresses are 0 status, 1 control, 2 command, 3 address, 4 data low and 5 data high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| lnk_req_o | output | 1 | Link operation requested, held until done |
| lnk_op_o | output | 2 | Link operation: 0 start, 1 transmit, 2 receive, 3 stop |
| lnk_txd_o | output | 8 | Byte to transmit |
| lnk_nack_o | output | 1 | On receive, answer with NACK |
| lnk_done_i | input | 1 | Current link operation finished (one-cycle pulse) |
| lnk_ack_i | input | 1 | On transmit, the byte was acknowledged |
| lnk_rxd_i | input | 8 | Received byte, valid with done |

## Verification
The bench sweeps every type code in both directions over several data patterns. It checks the link operation count, the last address byte, the NACK pattern on received bytes and the data that lands in the bus model or in the data registers. This catches a read that skips the repeated start, a read that keeps the write bit, or a word that swaps its bytes. Address and command NACKs must end as device error with a short operation count. A kill must stop early with the failed flag, and a kill issued while idle must not affect a later transaction. A design that let start or data writes through while busy would corrupt the transaction in flight. The bench also checks that result flags are sticky and accumulate, that they clear only on a written 1, and that the busy bit ignores writes.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;
  localparam int BYTE_W  = 8;
  localparam int RSEL_W  = 3;
  localparam int PROTO_W = 3;

  localparam logic [RSEL_W-1:0] RG_STAT = 3'd0;
  localparam logic [RSEL_W-1:0] RG_CTRL = 3'd1;
  localparam logic [RSEL_W-1:0] RG_CMD  = 3'd2;
  localparam logic [RSEL_W-1:0] RG_ADDR = 3'd3;
  localparam logic [RSEL_W-1:0] RG_DAT0 = 3'd4;
  localparam logic [RSEL_W-1:0] RG_DAT1 = 3'd5;

  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_PLO   = 2;
  localparam int CT_START = 6;
  localparam int CT_PEC   = 7;

  localparam logic [PROTO_W-1:0] PR_QUICK = 3'd0;
  localparam logic [PROTO_W-1:0] PR_BYTE  = 3'd1;
  localparam logic [PROTO_W-1:0] PR_BDATA = 3'd2;
  localparam logic [PROTO_W-1:0] PR_WDATA = 3'd3;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_TX    = 2'd1,
    OP_RX    = 2'd2,
    OP_STOP  = 2'd3
  } lnk_op_e;

  typedef struct packed {
    logic fail;
    logic dev;
    logic ok;
  } res_t;
endpackage

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RSEL_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              fin_i,
  input  res_t              res_i,
  input  logic              rx_we0_i,
  input  logic              rx_we1_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              go_o,
  output logic              busy_o,
  output logic              kill_o,
  output logic [PROTO_W-1:0] proto_o,
  output logic [BYTE_W-1:0] xaddr_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o
);
  logic busy_q, go_q, kill_q, ien_q, pec_q;
  logic [PROTO_W-1:0] proto_q;
  logic [BYTE_W-1:0]  cmd_q, xa_q, d0_q, d1_q;
  logic [3:0]         sts_q;  // status bits 4:1
  logic               wr_ctrl, start_acc, sw_wr;
  logic [3:0]         sts_set, sts_clr;

  assign wr_ctrl   = we_i && (addr_i == RG_CTRL);
  assign start_acc = wr_ctrl && wdata_i[CT_START] && !busy_q;
  assign sw_wr     = we_i && !busy_q;
  assign sts_set   = fin_i ? {res_i.fail, 1'b0, res_i.dev, res_i.ok} : 4'b0;
  assign sts_clr   = (we_i && addr_i == RG_STAT) ? wdata_i[4:1] : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; go_q <= 1'b0; kill_q <= 1'b0;
      ien_q <= 1'b0; pec_q <= 1'b0; proto_q <= '0;
      cmd_q <= '0; xa_q <= '0; d0_q <= '0; d1_q <= '0; sts_q <= '0;
    end else begin
      go_q <= start_acc;
      if (start_acc)  busy_q <= 1'b1;
      else if (fin_i) busy_q <= 1'b0;
      if (fin_i)      kill_q <= 1'b0;
      else if (wr_ctrl && wdata_i[CT_KILL] && busy_q) kill_q <= 1'b1;
      if (wr_ctrl && !busy_q) begin
        ien_q   <= wdata_i[CT_IEN];
        pec_q   <= wdata_i[CT_PEC];
        proto_q <= wdata_i[CT_PLO +: PROTO_W];
      end
      if (sw_wr && addr_i == RG_CMD)  cmd_q <= wdata_i;
      if (sw_wr && addr_i == RG_ADDR) xa_q  <= wdata_i;
      if (rx_we0_i)                        d0_q <= rx_byte_i;
      else if (sw_wr && addr_i == RG_DAT0) d0_q <= wdata_i;
      if (rx_we1_i)                        d1_q <= rx_byte_i;
      else if (sw_wr && addr_i == RG_DAT1) d1_q <= wdata_i;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  always_comb begin
    case (addr_i)
      RG_STAT: rdata_o = {3'b000, sts_q, busy_q};
      RG_CTRL: rdata_o = {pec_q, 2'b00, proto_q, 1'b0, ien_q};
      RG_CMD:  rdata_o = cmd_q;
      RG_ADDR: rdata_o = xa_q;
      RG_DAT0: rdata_o = d0_q;
      RG_DAT1: rdata_o = d1_q;
      default: rdata_o = '0;
    endcase
  end

  assign go_o    = go_q;
  assign busy_o  = busy_q;
  assign kill_o  = kill_q;
  assign proto_o = proto_q;
  assign xaddr_o = xa_q;
  assign cmd_o   = cmd_q;
  assign d0_o    = d0_q;
  assign d1_o    = d1_q;

  assert_busy_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(fin_i));
  assert_fin_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |-> $onehot(res_i) && busy_q);
  assert_sts_only_at_fin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[0]) |-> $past(fin_i));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && wr_ctrl |=> $stable(proto_q) && !go_q);
endmodule

// File: rtl/smbus_host_fsm.sv
module smbus_host_fsm
  import smbus_host_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [PROTO_W-1:0] proto_i,
  input  logic               kill_i,
  input  logic [BYTE_W-1:0]  xaddr_i,
  input  logic [BYTE_W-1:0]  cmd_i,
  input  logic [BYTE_W-1:0]  d0_i,
  input  logic [BYTE_W-1:0]  d1_i,
  output logic               lnk_req_o,
  output logic [1:0]         lnk_op_o,
  output logic [BYTE_W-1:0]  lnk_txd_o,
  output logic               lnk_nack_o,
  input  logic               lnk_done_i,
  input  logic               lnk_ack_i,
  input  logic [BYTE_W-1:0]  lnk_rxd_i,
  output logic               fin_o,
  output res_t               res_o,
  output logic               rx_we0_o,
  output logic               rx_we1_o,
  output logic [BYTE_W-1:0]  rx_byte_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_WD0, S_WD1,
    S_RSTART, S_RADDR, S_RD0, S_RD1, S_STOP
  } st_e;

  st_e     st_q, st_d, nxt;
  logic    kf_q, kf_d, df_q, df_d;
  lnk_op_e op;
  logic    rd, two_phase, supported, is_word, rej;

  assign rd        = xaddr_i[0];
  assign is_word   = (proto_i == PR_WDATA);
  assign two_phase = rd && (proto_i == PR_BDATA || is_word);
  assign supported = (proto_i <= PR_WDATA);

  always_comb begin
    op = OP_STOP; lnk_txd_o = '0; lnk_nack_o = 1'b0;
    case (st_q)
      S_START, S_RSTART: op = OP_START;
      S_ADDR:  begin op = OP_TX; lnk_txd_o = {xaddr_i[7:1], rd && !two_phase}; end
      S_CMD:   begin op = OP_TX; lnk_txd_o = cmd_i; end
      S_WD0:   begin op = OP_TX; lnk_txd_o = d0_i; end
      S_WD1:   begin op = OP_TX; lnk_txd_o = d1_i; end
      S_RADDR: begin op = OP_TX; lnk_txd_o = {xaddr_i[7:1], 1'b1}; end
      S_RD0:   begin op = OP_RX; lnk_nack_o = !is_word; end
      S_RD1:   begin op = OP_RX; lnk_nack_o = 1'b1; end
      default: op = OP_STOP;
    endcase
  end

  // successor on a clean finish of the current operation
  always_comb begin
    case (st_q)
      S_START:  nxt = S_ADDR;
      S_ADDR:   if (proto_i == PR_QUICK)     nxt = S_STOP;
                else if (proto_i == PR_BYTE) nxt = rd ? S_RD0 : S_CMD;
                else                         nxt = S_CMD;
      S_CMD:    if (proto_i == PR_BYTE) nxt = S_STOP;
                else                    nxt = rd ? S_RSTART : S_WD0;
      S_WD0:    nxt = is_word ? S_WD1 : S_STOP;
      S_RSTART: nxt = S_RADDR;
      S_RADDR:  nxt = S_RD0;
      S_RD0:    nxt = is_word ? S_RD1 : S_STOP;
      default:  nxt = S_STOP;
    endcase
  end

  always_comb begin
    st_d = st_q; kf_d = kf_q; df_d = df_q;
    case (st_q)
      S_IDLE: if (go_i) begin
        kf_d = 1'b0; df_d = 1'b0;
        if (supported) st_d = S_START;
      end
      S_STOP: if (lnk_done_i) st_d = S_IDLE;
      default: if (lnk_done_i) begin
        if (kill_i) begin
          st_d = S_STOP; kf_d = 1'b1;
        end else if (op == OP_TX && !lnk_ack_i) begin
          st_d = S_STOP; df_d = 1'b1;
        end else begin
          st_d = nxt;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; kf_q <= 1'b0; df_q <= 1'b0;
    end else begin
      st_q <= st_d; kf_q <= kf_d; df_q <= df_d;
    end
  end

  assign rej        = (st_q == S_IDLE) && go_i && !supported;
  assign fin_o      = rej || (st_q == S_STOP && lnk_done_i);
  assign res_o.fail = rej || kf_q;
  assign res_o.dev  = !rej && !kf_q && df_q;
  assign res_o.ok   = !rej && !kf_q && !df_q;
  assign lnk_req_o  = (st_q != S_IDLE);
  assign lnk_op_o   = op;
  assign rx_we0_o   = lnk_done_i && (st_q == S_RD0);
  assign rx_we1_o   = lnk_done_i && (st_q == S_RD1);
  assign rx_byte_o  = lnk_rxd_i;

  assert_req_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_req_o && !lnk_done_i |=> lnk_req_o && $stable(lnk_op_o) && $stable(lnk_txd_o));
  assert_kill_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_req_o && lnk_done_i && kill_i && lnk_op_o != OP_STOP |=> lnk_op_o == OP_STOP);
  assert_nack_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_req_o && lnk_done_i && lnk_op_o == OP_TX && !lnk_ack_i |=> lnk_op_o == OP_STOP);
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
  import smbus_host_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        lnk_req_o,
  output logic [1:0]  lnk_op_o,
  output logic [7:0]  lnk_txd_o,
  output logic        lnk_nack_o,
  input  logic        lnk_done_i,
  input  logic        lnk_ack_i,
  input  logic [7:0]  lnk_rxd_i
);
  logic               go, busy, kill, fin, rx_we0, rx_we1;
  res_t               res;
  logic [PROTO_W-1:0] proto;
  logic [BYTE_W-1:0]  xaddr, cmd, d0, d1, rx_byte;

  smbus_host_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .fin_i(fin), .res_i(res), .rx_we0_i(rx_we0), .rx_we1_i(rx_we1), .rx_byte_i(rx_byte),
    .go_o(go), .busy_o(busy), .kill_o(kill), .proto_o(proto),
    .xaddr_o(xaddr), .cmd_o(cmd), .d0_o(d0), .d1_o(d1)
  );

  smbus_host_fsm u_fsm (
    .clk_i, .rst_ni,
    .go_i(go), .proto_i(proto), .kill_i(kill),
    .xaddr_i(xaddr), .cmd_i(cmd), .d0_i(d0), .d1_i(d1),
    .lnk_req_o, .lnk_op_o, .lnk_txd_o, .lnk_nack_o,
    .lnk_done_i, .lnk_ack_i, .lnk_rxd_i,
    .fin_o(fin), .res_o(res), .rx_we0_o(rx_we0), .rx_we1_o(rx_we1), .rx_byte_o(rx_byte)
  );

  assert_idle_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !lnk_req_o);
endmodule

// File: tb/smbus_host_seq_tb_top.sv
module smbus_host_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic lnk_req, lnk_nack;
  logic [1:0] lnk_op;
  logic [7:0] lnk_txd;
  logic lnk_done = 1'b0, lnk_ack = 1'b0;
  logic [7:0] lnk_rxd = '0;

  int checks = 0, errors = 0;

  // bus model state
  logic [7:0] mem [16];
  logic [7:0] byte_reg, last_addr, cmd_seen;
  logic [3:0] ptr;
  logic ptr_v, sel, rw, phase_addr;
  logic [7:0] rx_bits;
  int ops, rx_cnt, nb, lat, wcnt;
  logic [1:0] last_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_host_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .lnk_req_o(lnk_req), .lnk_op_o(lnk_op), .lnk_txd_o(lnk_txd), .lnk_nack_o(lnk_nack),
    .lnk_done_i(lnk_done), .lnk_ack_i(lnk_ack), .lnk_rxd_i(lnk_rxd)
  );

  initial begin
    ops = 0; rx_cnt = 0; nb = 0; lat = 0; wcnt = 0; rx_bits = '0; ptr = '0; ptr_v = 1'b0;
    sel = 1'b0; rw = 1'b0; phase_addr = 1'b0; last_op = '0; last_addr = '0;
    byte_reg = '0; cmd_seen = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      lnk_done = 1'b0;
      if (lnk_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; ops++; last_op = lnk_op; lnk_ack = 1'b0;
          case (lnk_op)
            2'd0: phase_addr = 1'b1;
            2'd1: begin
              if (phase_addr) begin
                sel = (lnk_txd[7:1] == SLV); rw = lnk_txd[0]; last_addr = lnk_txd;
                lnk_ack = sel; phase_addr = 1'b0; nb = 0;
              end else if (sel) begin
                if (nb == 0 && !ptr_v) begin
                  if (lnk_txd != 8'hEE) begin
                    ptr = lnk_txd[3:0]; ptr_v = 1'b1; cmd_seen = lnk_txd; lnk_ack = 1'b1; nb++;
                  end
                end else begin
                  mem[ptr] = lnk_txd; ptr = ptr + 4'd1; lnk_ack = 1'b1; nb++;
                end
              end
            end
            2'd2: begin
              if (ptr_v) begin lnk_rxd = mem[ptr]; ptr = ptr + 4'd1; end
              else lnk_rxd = byte_reg;
              rx_bits = {rx_bits[6:0], lnk_nack}; rx_cnt++;
            end
            default: begin
              if (sel && !rw && nb == 1) byte_reg = cmd_seen;
              ptr_v = 1'b0; sel = 1'b0;
            end
          endcase
          lnk_done = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    we = 1'b0; addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n;
    n = 0;
    do begin
      @(negedge clk); reg_rd(3'd0, s); n++;
    end while (s[0] && n < 5000);
    if (n >= 5000) chk("R2 busy timeout", 16'(s), 16'h0);
  endtask

  task automatic start_txn(input logic [2:0] p, input logic [7:0] xa, input logic [7:0] c,
                           input logic [7:0] d0, input logic [7:0] d1);
    reg_wr(3'd0, 8'h1E);
    reg_wr(3'd3, xa); reg_wr(3'd2, c); reg_wr(3'd4, d0); reg_wr(3'd5, d1);
    ops = 0; rx_cnt = 0; rx_bits = '0;
    reg_wr(3'd1, 8'(8'h40 | (p << 2)));
  endtask

  function automatic int exp_ops(input int p, input int r);
    case (p)
      0: return 3;
      1: return 4;
      2: return r ? 7 : 5;
      default: return r ? 8 : 6;
    endcase
  endfunction

  initial begin : main
    logic [7:0] v, v1, st;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), v); chk("R1 reg reset", 16'(v), 16'h0);
    end
    chk("R1 no link request", 16'(lnk_req), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R8: sweep of types, directions, patterns
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 2; r++) begin
        for (int pat = 0; pat < 3; pat++) begin
          logic [7:0] c, d0v, d1v, br;
          c   = 8'((p * 3 + pat * 5 + r) % 14);
          d0v = 8'(p * 37 + pat * 91 + r * 11 + 3);
          d1v = 8'((d0v ^ 8'h5A) + 8'(pat));
          for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + pat * 29 + p);
          br = 8'(8'hC3 ^ 8'(pat * 7 + p));
          byte_reg = br;
          if (r == 1) start_txn(3'(p), {SLV, 1'b1}, c, 8'h00, 8'h00);
          else        start_txn(3'(p), {SLV, 1'b0}, c, d0v, d1v);
          wait_idle();
          reg_rd(3'd0, st);
          if (p >= 4) begin
            chk("R8 status", 16'(st), 16'h10);
            chk("R8 no link ops", 16'(ops), 16'h0);
          end else begin
            chk("R2 status ok", 16'(st), 16'h02);
            chk("R3 op count", 16'(ops), 16'(exp_ops(p, r)));
            chk("R3 address byte", 16'(last_addr), 16'({SLV, 1'(r)}));
            if (r == 0) begin
              if (p == 1) chk("R4 send byte", 16'(byte_reg), 16'(c));
              if (p >= 2) chk("R4 data low", 16'(mem[c[3:0]]), 16'(d0v));
              if (p == 3) chk("R4 data high", 16'(mem[c[3:0] + 4'd1]), 16'(d1v));
            end else if (p >= 1) begin
              reg_rd(3'd4, v); reg_rd(3'd5, v1);
              if (p == 1) chk("R5 receive byte", 16'(v), 16'(br));
              else        chk("R5 data low", 16'(v), 16'(8'(c * 17 + pat * 29 + p)));
              if (p == 3) begin
                chk("R5 data high", 16'(v1), 16'(8'((c + 1) * 17 + pat * 29 + p)));
                chk("R5 ack then nack", 16'(rx_bits), 16'h01);
              end else begin
                chk("R5 data high untouched", 16'(v1), 16'h00);
                chk("R5 single nack", 16'(rx_bits), 16'h01);
              end
            end
          end
        end
      end
    end

    // R2: busy visible, start bit reads 0
    lat = 3;
    start_txn(3'd2, {SLV, 1'b0}, 8'd4, 8'h11, 8'h22);
    reg_rd(3'd0, v); chk("R2 busy set", 16'(v[0]), 16'h1);
    reg_rd(3'd1, v); chk("R2 start reads 0", 16'(v), 16'h08);
    wait_idle();
    reg_rd(3'd0, v); chk("R2 done only", 16'(v), 16'h02);

    // R6: address nack, command nack
    lat = 0;
    start_txn(3'd3, {7'h33, 1'b0}, 8'd2, 8'h01, 8'h02);
    wait_idle();
    reg_rd(3'd0, v); chk("R6 addr nack status", 16'(v), 16'h04);
    chk("R6 addr nack ops", 16'(ops), 16'd3);
    chk("R6 stop issued", 16'(last_op), 16'd3);
    start_txn(3'd2, {SLV, 1'b0}, 8'hEE, 8'h01, 8'h02);
    wait_idle();
    reg_rd(3'd0, v); chk("R6 cmd nack status", 16'(v), 16'h04);
    chk("R6 cmd nack ops", 16'(ops), 16'd4);

    // R7: kill while busy
    lat = 10;
    start_txn(3'd3, {SLV, 1'b0}, 8'd6, 8'h33, 8'h44);
    repeat (15) @(negedge clk);
    reg_wr(3'd1, 8'h02);
    wait_idle();
    reg_rd(3'd0, v); chk("R7 kill status", 16'(v), 16'h10);
    chk("R7 stopped early", 16'(ops < 6), 16'h1);
    chk("R7 stop issued", 16'(last_op), 16'd3);
    // R7: kill while idle has no effect
    lat = 0;
    reg_wr(3'd1, 8'h02);
    start_txn(3'd2, {SLV, 1'b0}, 8'd7, 8'h5C, 8'h00);
    wait_idle();
    reg_rd(3'd0, v); chk("R7 idle kill ignored", 16'(v), 16'h02);
    chk("R7 idle kill data", 16'(mem[7]), 16'h5C);

    // R10: start and data writes while busy ignored
    lat = 5;
    start_txn(3'd3, {SLV, 1'b0}, 8'd9, 8'hA1, 8'hB2);
    reg_wr(3'd1, 8'h40);
    reg_wr(3'd4, 8'hFF);
    reg_wr(3'd2, 8'd1);
    wait_idle();
    reg_rd(3'd0, v); chk("R10 status", 16'(v), 16'h02);
    chk("R10 op count", 16'(ops), 16'd6);
    chk("R10 low byte kept", 16'(mem[9]), 16'hA1);
    chk("R10 high byte kept", 16'(mem[10]), 16'hB2);
    reg_rd(3'd4, v); chk("R10 data low reg", 16'(v), 16'hA1);
    reg_rd(3'd1, v); chk("R10 type kept", 16'(v), 16'h0C);
    reg_rd(3'd2, v); chk("R10 command kept", 16'(v), 16'd9);

    // R9: sticky, write-one-to-clear
    lat = 0;
    start_txn(3'd7, {SLV, 1'b0}, 8'd0, 8'h0, 8'h0);
    wait_idle();
    ops = 0;
    reg_wr(3'd1, 8'h48);
    wait_idle();
    reg_rd(3'd0, v); chk("R9 accumulate", 16'(v), 16'h12);
    reg_wr(3'd0, 8'h00);
    reg_rd(3'd0, v); chk("R9 zero write keeps", 16'(v), 16'h12);
    reg_wr(3'd0, 8'h10);
    reg_rd(3'd0, v); chk("R9 clear failed", 16'(v), 16'h02);
    reg_wr(3'd0, 8'h01);
    reg_rd(3'd0, v); chk("R9 busy not writable", 16'(v), 16'h02);
    reg_wr(3'd0, 8'h02);
    reg_rd(3'd0, v); chk("R9 clear done", 16'(v), 16'h00);

    // R11: register map
    reg_wr(3'd5, 8'h6D);
    reg_rd(3'd5, v); chk("R11 data high addr", 16'(v), 16'h6D);
    reg_rd(3'd3, v); chk("R11 address addr", 16'(v), 16'({SLV, 1'b0}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule